// File: doc/BRIEF.md
# DDR2 Rank Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 interface. It takes one or two memory ranks from power-up to the point where normal traffic and periodic refresh may begin. After reset it keeps the clock-enable pin low. It waits until the PHY reports that its delay-locked loop has locked, and until a power-on stable-clock interval has elapsed. It then drives the JEDEC power-up command series on a registered command bus, spacing every command by a programmable timing gap and filling the gaps with NOPs.

The series is run for rank 0 and then, when two ranks are requested at start, for rank 1. The series opens with a NOP that raises CKE. It continues with precharge-all, the three extended mode-register writes and the mode-register write that resets the memory DLL. A second precharge-all, two refreshes and a mode-register write without DLL reset follow. A 200-cycle DLL settle wait, OCD-default and OCD-exit writes close it. Only after the last rank is finished does the block raise its done flag and the enable for the refresh engine. The mode-register operand inputs are used directly when each write is issued, so they must stay constant while the block is busy.

Top module: `ddr2_init_seq`

## Requirements
- R1: After a synchronous reset the block is idle: `cke_o` is 0, `cs_n_o` is 2'b11, `ras_n_o`/`cas_n_o`/`we_n_o` are 1, and `busy_o`, `done_o`, `aref_en_o` are 0. CKE stays low and no rank is selected until the first NOP.
- R2: A `start_i` pulse in idle raises `busy_o` on the next cycle. No command is driven while `dll_locked_i` is 0. Once the power-on interval is over, the first NOP is on the bus one cycle after `dll_locked_i` is seen high.
- R3: No command appears before CLK_MHZ*T_STABLE_US clock cycles have passed since reset was released.
- R4: Every rank's series starts with a NOP (its chip select low, RAS/CAS/WE = 1/1/1). The first one drives `cke_o` high, and CKE stays high until the next reset.
- R5: After the NOP the commands come in the fixed order: precharge-all, EMRS2, EMRS3, EMRS with memory DLL enabled, MRS with DLL reset, precharge-all, refresh, refresh, MRS without DLL reset, EMRS with OCD default, EMRS with OCD exit.
- R6: Encodings: precharge-all is RAS/CAS/WE = 0/1/0 with A10 = 1. Refresh is 0/0/1. A mode-register write is 0/0/0 with BA = 2'b00 (MRS), 2'b01 (EMRS), 2'b10 (EMRS2) or 2'b11 (EMRS3). Rank r is selected by `cs_n_o[r]` = 0, and at most one bit is ever low.
- R7: Write operands: EMRS2/EMRS3 carry `emr2_i`/`emr3_i` unchanged. Every EMRS carries `emr_i` with A0 cleared (DLL enabled). A9:A7 are 000 in the DLL-enable and OCD-exit writes and 111 in the OCD-default write. The first MRS carries `mr_i` with A8 set, the second `mr_i` with A8 cleared.
- R8: The cycle distance from a command to the next one is: ceil(T_CKE_NS*CLK_MHZ/1000) after the opening NOP, T_RP_CYC after precharge-all, T_MRD_CYC after EMRS2, EMRS3, the first EMRS, the first MRS and each OCD write, T_RFC_CYC after each refresh, and T_DLL_CYC after the second MRS. NOPs to the active rank fill the gaps.
- R9: `two_ranks_i` is captured with the start pulse. If it was 1, rank 1 (`cs_n_o` = 2'b01) gets the complete series from its NOP onward, starting T_MRD_CYC cycles after rank 0's OCD-exit write.
- R10: `done_o` and `aref_en_o` rise and `busy_o` falls T_MRD_CYC cycles after the last rank's OCD-exit write. `aref_en_o` is 0 before that. Afterwards no rank is selected, CKE stays high, and done holds until reset.
- R11: `start_i` has no effect while busy or done, even when `two_ranks_i` changes with it.
- R12: Reset asserted during the series returns the block to the R1 idle state on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin initialization |
| dll_locked_i | input | 1 | PHY delay-locked loop has locked |
| two_ranks_i | input | 1 | 1 = initialize ranks 0 and 1, 0 = rank 0 only |
| mr_i | input | ADDR_W | Mode register operating value |
| emr_i | input | ADDR_W | Extended mode register operating value |
| emr2_i | input | ADDR_W | Extended mode register 2 value |
| emr3_i | input | ADDR_W | Extended mode register 3 value |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 2 | Chip selects, one per rank, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address / mode register select |
| addr_o | output | ADDR_W | Address / mode register operand |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | All requested ranks initialized |
| aref_en_o | output | 1 | Permission for the periodic refresh engine |

## Verification
Every command's timing is fixed relative to the one before it. The opening NOP follows the lock sample by one cycle, each later command follows its predecessor by exactly the gap of R8, and done follows the last OCD-exit write by T_MRD_CYC. The driver pushes each expected command together with its required distance from the previous command. The monitor samples the bus mid-cycle, stamps each command with the cycle counter and compares both the encoding and the distance. The power-on interval is checked as a window on the first command's stamp measured from reset release. Ignored starts are checked by the absence of any extra bus activity in the cycles that follow.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    localparam int NUM_CS    = 2;
    localparam int STEP_W    = 4;
    localparam int LAST_STEP = 11;

    // Address bits with a fixed meaning in the mode-register writes
    localparam int BIT_PALL   = 10;
    localparam int BIT_DLLRST = 8;
    localparam int BIT_DLLDIS = 0;
    localparam int OCD_LSB    = 7;

    typedef enum logic [2:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_PALL,
        CMD_MODE,
        CMD_REF
    } cmd_e;

    typedef enum logic [3:0] {
        ASRC_ZERO,
        ASRC_PALL,
        ASRC_EMR2,
        ASRC_EMR3,
        ASRC_EMR_DLLON,
        ASRC_MR_RESET,
        ASRC_MR_RUN,
        ASRC_EMR_OCDDEF,
        ASRC_EMR_OCDEXIT
    } asrc_e;

    typedef enum logic [2:0] {
        GAP_CKE,
        GAP_RP,
        GAP_MRD,
        GAP_RFC,
        GAP_DLL
    } gap_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READY,
        ST_RUN,
        ST_DONE
    } fsm_e;

    typedef struct packed {
        cmd_e       cmd;
        logic [1:0] ba;
        asrc_e      asrc;
        gap_e       gap;
    } step_t;

endpackage

// File: rtl/ddr2_init_step_table.sv
module ddr2_init_step_table
    import ddr2_init_pkg::*;
(
    input  logic [STEP_W-1:0] step_i,
    output step_t             step_o
);

    always_comb begin
        step_o = '{cmd: CMD_NOP, ba: 2'b00, asrc: ASRC_ZERO, gap: GAP_CKE};
        case (step_i)
            4'd0:  step_o = '{cmd: CMD_NOP,  ba: 2'b00, asrc: ASRC_ZERO,        gap: GAP_CKE};
            4'd1:  step_o = '{cmd: CMD_PALL, ba: 2'b00, asrc: ASRC_PALL,        gap: GAP_RP};
            4'd2:  step_o = '{cmd: CMD_MODE, ba: 2'b10, asrc: ASRC_EMR2,        gap: GAP_MRD};
            4'd3:  step_o = '{cmd: CMD_MODE, ba: 2'b11, asrc: ASRC_EMR3,        gap: GAP_MRD};
            4'd4:  step_o = '{cmd: CMD_MODE, ba: 2'b01, asrc: ASRC_EMR_DLLON,   gap: GAP_MRD};
            4'd5:  step_o = '{cmd: CMD_MODE, ba: 2'b00, asrc: ASRC_MR_RESET,    gap: GAP_MRD};
            4'd6:  step_o = '{cmd: CMD_PALL, ba: 2'b00, asrc: ASRC_PALL,        gap: GAP_RP};
            4'd7:  step_o = '{cmd: CMD_REF,  ba: 2'b00, asrc: ASRC_ZERO,        gap: GAP_RFC};
            4'd8:  step_o = '{cmd: CMD_REF,  ba: 2'b00, asrc: ASRC_ZERO,        gap: GAP_RFC};
            4'd9:  step_o = '{cmd: CMD_MODE, ba: 2'b00, asrc: ASRC_MR_RUN,      gap: GAP_DLL};
            4'd10: step_o = '{cmd: CMD_MODE, ba: 2'b01, asrc: ASRC_EMR_OCDDEF,  gap: GAP_MRD};
            4'd11: step_o = '{cmd: CMD_MODE, ba: 2'b01, asrc: ASRC_EMR_OCDEXIT, gap: GAP_MRD};
            default: ;
        endcase
    end

endmodule

// File: rtl/ddr2_init_gap_timer.sv
module ddr2_init_gap_timer
    import ddr2_init_pkg::*;
#(
    parameter int CKE_CYC = 100,
    parameter int RP_CYC  = 4,
    parameter int MRD_CYC = 2,
    parameter int RFC_CYC = 32,
    parameter int DLL_CYC = 200
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic load_i,
    input  gap_e sel_i,
    output logic expired_o
);

    localparam int M1   = (CKE_CYC > RP_CYC)  ? CKE_CYC : RP_CYC;
    localparam int M2   = (M1 > MRD_CYC)      ? M1      : MRD_CYC;
    localparam int M3   = (M2 > RFC_CYC)      ? M2      : RFC_CYC;
    localparam int MAXC = (M3 > DLL_CYC)      ? M3      : DLL_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] len;

    always_comb begin
        case (sel_i)
            GAP_RP:  len = CW'(RP_CYC - 1);
            GAP_MRD: len = CW'(MRD_CYC - 1);
            GAP_RFC: len = CW'(RFC_CYC - 1);
            GAP_DLL: len = CW'(DLL_CYC - 1);
            default: len = CW'(CKE_CYC - 1);
        endcase
        if (load_i) begin
            cnt_d = len;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/ddr2_init_pwr_timer.sv
module ddr2_init_pwr_timer #(
    parameter int LIMIT = 50000
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic reached_o
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == CW'(LIMIT)) ? cnt_q : cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign reached_o = (cnt_q == CW'(LIMIT));

endmodule

// File: rtl/ddr2_init_cmd_enc.sv
module ddr2_init_cmd_enc
    import ddr2_init_pkg::*;
(
    input  cmd_e              cmd_i,
    input  logic              rank_i,
    output logic [NUM_CS-1:0] cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o
);

    logic sel;

    always_comb begin
        sel = (cmd_i != CMD_DESEL);
        case (cmd_i)
            CMD_PALL: {ras_n_o, cas_n_o, we_n_o} = 3'b010;
            CMD_MODE: {ras_n_o, cas_n_o, we_n_o} = 3'b000;
            CMD_REF:  {ras_n_o, cas_n_o, we_n_o} = 3'b001;
            default:  {ras_n_o, cas_n_o, we_n_o} = 3'b111;
        endcase
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_n_o[g] = !(sel && (rank_i == 1'(g)));
    end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int ADDR_W      = 14,
    parameter int CLK_MHZ     = 250,
    parameter int T_STABLE_US = 200,
    parameter int T_CKE_NS    = 400,
    parameter int T_RP_CYC    = 4,
    parameter int T_MRD_CYC   = 2,
    parameter int T_RFC_CYC   = 32,
    parameter int T_DLL_CYC   = 200
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic              dll_locked_i,
    input  logic              two_ranks_i,
    input  logic [ADDR_W-1:0] mr_i,
    input  logic [ADDR_W-1:0] emr_i,
    input  logic [ADDR_W-1:0] emr2_i,
    input  logic [ADDR_W-1:0] emr3_i,
    output logic              cke_o,
    output logic [1:0]        cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [1:0]        ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              aref_en_o
);

    localparam int STABLE_CYC = CLK_MHZ * T_STABLE_US;
    localparam int CKE_CYC    = (T_CKE_NS * CLK_MHZ + 999) / 1000;

    localparam logic [ADDR_W-1:0] M_PALL   = ADDR_W'(1) << BIT_PALL;
    localparam logic [ADDR_W-1:0] M_DLLRST = ADDR_W'(1) << BIT_DLLRST;
    localparam logic [ADDR_W-1:0] M_DLLDIS = ADDR_W'(1) << BIT_DLLDIS;
    localparam logic [ADDR_W-1:0] M_OCD    = ADDR_W'(7) << OCD_LSB;

    typedef struct packed {
        fsm_e              fsm;
        logic [STEP_W-1:0] step;
        logic              rank;
        logic              two;
        logic              cke;
        cmd_e              cmd;
        logic [1:0]        ba;
        logic [ADDR_W-1:0] addr;
    } regs_t;

    regs_t r_d, r_q;

    logic              stable_ok;
    logic              tmr_expired;
    logic              tmr_load;
    logic              issue;
    logic [STEP_W-1:0] issue_step;
    logic              issue_rank;
    step_t             stp;
    logic [ADDR_W-1:0] op_addr;
    logic [ADDR_W-1:0] emr_base;

    ddr2_init_pwr_timer #(.LIMIT(STABLE_CYC)) i_pwr (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .reached_o (stable_ok)
    );

    ddr2_init_gap_timer #(
        .CKE_CYC (CKE_CYC),
        .RP_CYC  (T_RP_CYC),
        .MRD_CYC (T_MRD_CYC),
        .RFC_CYC (T_RFC_CYC),
        .DLL_CYC (T_DLL_CYC)
    ) i_gap (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .load_i    (tmr_load),
        .sel_i     (stp.gap),
        .expired_o (tmr_expired)
    );

    ddr2_init_step_table i_tbl (
        .step_i (issue_step),
        .step_o (stp)
    );

    ddr2_init_cmd_enc i_enc (
        .cmd_i   (r_q.cmd),
        .rank_i  (r_q.rank),
        .cs_n_o  (cs_n_o),
        .ras_n_o (ras_n_o),
        .cas_n_o (cas_n_o),
        .we_n_o  (we_n_o)
    );

    // Next step / rank selection
    always_comb begin
        issue      = 1'b0;
        issue_step = r_q.step;
        issue_rank = r_q.rank;
        case (r_q.fsm)
            ST_READY: begin
                if (dll_locked_i && stable_ok) begin
                    issue      = 1'b1;
                    issue_step = '0;
                    issue_rank = 1'b0;
                end
            end
            ST_RUN: begin
                if (tmr_expired) begin
                    if (r_q.step != STEP_W'(LAST_STEP)) begin
                        issue      = 1'b1;
                        issue_step = r_q.step + 1'b1;
                    end else if (!r_q.rank && r_q.two) begin
                        issue      = 1'b1;
                        issue_step = '0;
                        issue_rank = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    // Operand for the selected step
    always_comb begin
        emr_base = emr_i & ~(M_DLLDIS | M_OCD);
        case (stp.asrc)
            ASRC_PALL:        op_addr = M_PALL;
            ASRC_EMR2:        op_addr = emr2_i;
            ASRC_EMR3:        op_addr = emr3_i;
            ASRC_EMR_DLLON:   op_addr = emr_base;
            ASRC_MR_RESET:    op_addr = mr_i | M_DLLRST;
            ASRC_MR_RUN:      op_addr = mr_i & ~M_DLLRST;
            ASRC_EMR_OCDDEF:  op_addr = emr_base | M_OCD;
            ASRC_EMR_OCDEXIT: op_addr = emr_base;
            default:          op_addr = '0;
        endcase
    end

    // Next-state computation
    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        case (r_q.fsm)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.fsm = ST_READY;
                    r_d.two = two_ranks_i;
                end
            end
            ST_READY: begin
                if (issue) begin
                    r_d.fsm = ST_RUN;
                    r_d.cke = 1'b1;
                end
            end
            ST_RUN: begin
                if (tmr_expired && !issue) begin
                    r_d.fsm = ST_DONE;
                end
            end
            default: ;
        endcase

        r_d.cmd  = (r_d.fsm == ST_RUN) ? CMD_NOP : CMD_DESEL;
        r_d.ba   = '0;
        r_d.addr = '0;
        if (issue) begin
            r_d.step = issue_step;
            r_d.rank = issue_rank;
            r_d.cmd  = stp.cmd;
            r_d.ba   = stp.ba;
            r_d.addr = op_addr;
            tmr_load = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q <= '{fsm: ST_IDLE, step: '0, rank: 1'b0, two: 1'b0, cke: 1'b0,
                     cmd: CMD_DESEL, ba: '0, addr: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cke_o     = r_q.cke;
    assign ba_o      = r_q.ba;
    assign addr_o    = r_q.addr;
    assign busy_o    = (r_q.fsm == ST_READY) || (r_q.fsm == ST_RUN);
    assign done_o    = (r_q.fsm == ST_DONE);
    assign aref_en_o = (r_q.fsm == ST_DONE);

endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              dll_locked,
    input logic              cke,
    input logic [1:0]        cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              busy,
    input logic              done,
    input logic              aref_en
);

    // R1: idle keeps CKE low
    assert_cke_low_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done) |-> !cke);

    // R1: no chip select without CKE
    assert_no_select_before_cke_R1: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (cs_n == 2'b11));

    // R2: CKE only rises after the lock flag was seen
    assert_cke_rise_after_lock_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> $past(dll_locked));

    // R4: CKE never falls outside reset
    assert_cke_hold_R4: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

    // R6: precharge-all carries A10
    assert_pall_a10_R6: assert property (@(posedge clk) disable iff (rst)
        ((cs_n != 2'b11) && !ras_n && cas_n && !we_n) |-> addr[10]);

    // R6: one rank at a time
    assert_single_rank_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    // R11: busy only ends by completing
    assert_busy_exit_R11: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done));

    // R10: completion is sticky and enables refresh
    assert_done_hold_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> (done && aref_en && !busy));

endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk        (clk_i),
    .rst        (rst_i),
    .dll_locked (dll_locked_i),
    .cke        (cke_o),
    .cs_n       (cs_n_o),
    .ras_n      (ras_n_o),
    .cas_n      (cas_n_o),
    .we_n       (we_n_o),
    .addr       (addr_o),
    .busy       (busy_o),
    .done       (done_o),
    .aref_en    (aref_en_o)
);

// File: tb/test_ddr2_init_seq.sv
`timescale 1ns/1ps
module test_ddr2_init_seq;

    localparam int AW     = 14;
    localparam int MHZ    = 250;
    localparam int STB_US = 2;
    localparam int S_CYC  = MHZ * STB_US;
    localparam int NOPW   = (400 * MHZ + 999) / 1000;
    localparam int TRP    = 4;
    localparam int TMRD   = 2;
    localparam int TRFC   = 32;
    localparam int TDLL   = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic lock = 1'b0;
    logic two = 1'b0;
    logic [AW-1:0] mr = '0, emr = '0, emr2 = '0, emr3 = '0;
    logic cke, ras_n, cas_n, we_n, busy, done, aref;
    logic [1:0] cs_n, ba;
    logic [AW-1:0] addr;

    always #2 clk = ~clk;

    ddr2_init_seq #(
        .ADDR_W(AW), .CLK_MHZ(MHZ), .T_STABLE_US(STB_US), .T_CKE_NS(400),
        .T_RP_CYC(TRP), .T_MRD_CYC(TMRD), .T_RFC_CYC(TRFC), .T_DLL_CYC(TDLL)
    ) i_ddr2_init_seq (
        .clk_i(clk), .rst_i(rst), .start_i(start), .dll_locked_i(lock),
        .two_ranks_i(two), .mr_i(mr), .emr_i(emr), .emr2_i(emr2), .emr3_i(emr3),
        .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
        .ba_o(ba), .addr_o(addr), .busy_o(busy), .done_o(done), .aref_en_o(aref)
    );

    typedef struct packed {
        logic [1:0]    cs;
        logic [2:0]    rcw;
        logic [1:0]    ba;
        logic [AW-1:0] addr;
        logic [31:0]   gap;
    } item_t;

    item_t q_item[$];
    string q_tag[$];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int evt_count = 0;
    int first_evt_cyc = -1;
    int last_evt_cyc = 0;
    int done_cyc = -1;
    logic [1:0] prev_cs = 2'b11;
    logic prev_done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] c, input logic [2:0] rcw, input logic [1:0] b,
                        input logic [AW-1:0] a, input int g, input string tag);
        item_t it;
        it.cs = c; it.rcw = rcw; it.ba = b; it.addr = a; it.gap = 32'(g);
        q_item.push_back(it);
        q_tag.push_back(tag);
    endtask

    // Driver: expected series for one rank (R4-R8)
    task automatic push_rank(input bit rank, input int first_gap);
        logic [1:0] c;
        logic [AW-1:0] eb;
        c  = rank ? 2'b01 : 2'b10;
        eb = emr & ~(AW'(1) | (AW'(7) << 7));
        push(c, 3'b111, 2'b00, '0,                     first_gap, "R4 nop");
        push(c, 3'b010, 2'b00, AW'(1) << 10,           NOPW, "R5 pall");
        push(c, 3'b000, 2'b10, emr2,                   TRP,  "R7 emrs2");
        push(c, 3'b000, 2'b11, emr3,                   TMRD, "R7 emrs3");
        push(c, 3'b000, 2'b01, eb,                     TMRD, "R7 emrs dll on");
        push(c, 3'b000, 2'b00, mr | (AW'(1) << 8),     TMRD, "R7 mrs dll reset");
        push(c, 3'b010, 2'b00, AW'(1) << 10,           TMRD, "R6 pall");
        push(c, 3'b001, 2'b00, '0,                     TRP,  "R6 ref");
        push(c, 3'b001, 2'b00, '0,                     TRFC, "R8 ref");
        push(c, 3'b000, 2'b00, mr & ~(AW'(1) << 8),    TRFC, "R7 mrs run");
        push(c, 3'b000, 2'b01, eb | (AW'(7) << 7),     TDLL, "R8 ocd default");
        push(c, 3'b000, 2'b01, eb,                     TMRD, "R7 ocd exit");
    endtask

    // Monitor: compare bus events against the queue
    always @(negedge clk) begin
        if (rst) begin
            prev_cs = 2'b11;
            prev_done = 1'b0;
        end else begin
            if ({ras_n, cas_n, we_n} != 3'b111 || (cs_n != 2'b11 && cs_n != prev_cs)) begin
                evt_count++;
                if (first_evt_cyc < 0) first_evt_cyc = cyc;
                if (q_item.size() == 0) begin
                    chk(1'b0, "R5", "unexpected command", {27'd0, cs_n, ras_n, cas_n, we_n}, 0);
                end else begin
                    item_t it;
                    string tg;
                    it = q_item.pop_front();
                    tg = q_tag.pop_front();
                    chk(cs_n == it.cs, tg, "chip select", 32'(cs_n), 32'(it.cs));
                    chk({ras_n, cas_n, we_n} == it.rcw, tg, "ras/cas/we",
                        32'({ras_n, cas_n, we_n}), 32'(it.rcw));
                    chk(ba == it.ba, tg, "bank address", 32'(ba), 32'(it.ba));
                    chk(addr == it.addr, tg, "address", 32'(addr), 32'(it.addr));
                    if (it.gap != 0)
                        chk(32'(cyc - last_evt_cyc) == it.gap, "R8", tg,
                            32'(cyc - last_evt_cyc), it.gap);
                    chk(cke == 1'b1, "R4", "cke high at command", 32'(cke), 1);
                end
                last_evt_cyc = cyc;
            end
            if (done && !prev_done) done_cyc = cyc;
            prev_cs = cs_n;
            prev_done = done;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_start(input logic two_v);
        two = two_v;
        start = 1'b1;
        tick(1);
        start = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit && !done; i++) tick(1);
        tick(1);
    endtask

    task automatic finish_run(input string tag);
        chk(q_item.size() == 0, "R5", {tag, " queue drained"}, 32'(q_item.size()), 0);
        chk(done_cyc - last_evt_cyc == TMRD, "R10", {tag, " done latency"},
            32'(done_cyc - last_evt_cyc), TMRD);
        chk(aref && !busy && cke && cs_n == 2'b11, "R10", {tag, " final state"},
            {27'd0, aref, busy, cke, cs_n}, 32'b10111);
    endtask

    task automatic reset_idle_check(input string req);
        chk(!cke && cs_n == 2'b11 && ras_n && cas_n && we_n && !busy && !done && !aref,
            req, "idle state",
            {24'd0, cke, cs_n, ras_n, cas_n, we_n, busy, done}, 32'h0F8 >> 1 & 32'h07C);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lock_cyc;
        int rel_cyc;
        int n0;
        tick(5);
        // R1: reset state
        reset_idle_check("R1");

        // Run 1: one rank, lock arrives late
        mr = 14'h0163; emr = 14'h0385; emr2 = 14'h0080; emr3 = 14'h0000;
        rst = 1'b0;
        tick(2);
        pulse_start(1'b0);
        chk(busy == 1'b1, "R2", "busy after start", 32'(busy), 1);
        tick(S_CYC + 100);
        chk(cke == 1'b0 && evt_count == 0, "R2", "no command before lock",
            32'(evt_count), 0);
        push_rank(1'b0, 0);
        lock = 1'b1;
        lock_cyc = cyc;
        wait_done(2000);
        chk(first_evt_cyc - lock_cyc == 1, "R2", "nop after lock",
            32'(first_evt_cyc - lock_cyc), 1);
        finish_run("one rank");
        // R11: start after done is ignored
        n0 = evt_count;
        pulse_start(1'b1);
        tick(30);
        chk(evt_count == n0 && done && cs_n == 2'b11, "R11", "start after done",
            32'(evt_count - n0), 0);

        // Run 2: two ranks, lock already high
        rst = 1'b1;
        tick(3);
        reset_idle_check("R1");
        mr = 14'h0A42; emr = 14'h0046; emr2 = 14'h0000; emr3 = 14'h0123;
        first_evt_cyc = -1;
        done_cyc = -1;
        push_rank(1'b0, 0);
        push_rank(1'b1, TMRD);
        rel_cyc = cyc;
        rst = 1'b0;
        tick(1);
        pulse_start(1'b1);
        tick(40);
        pulse_start(1'b0);    // R11: ignored while busy, rank count kept
        tick(S_CYC + 150);
        pulse_start(1'b0);
        wait_done(4000);
        chk(first_evt_cyc - rel_cyc >= S_CYC && first_evt_cyc - rel_cyc <= S_CYC + 2,
            "R3", "power-on interval", 32'(first_evt_cyc - rel_cyc), S_CYC + 1);
        finish_run("two ranks R9");

        // Run 3: reset in the middle of the series
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        push_rank(1'b0, 0);
        n0 = evt_count;
        tick(1);
        pulse_start(1'b0);
        for (int i = 0; i < S_CYC + 400 && evt_count < n0 + 5; i++) tick(1);
        chk(evt_count == n0 + 5, "R12", "series under way", 32'(evt_count - n0), 5);
        rst = 1'b1;
        tick(1);
        reset_idle_check("R12");
        q_item.delete();
        q_tag.delete();
        rst = 1'b0;
        n0 = evt_count;
        tick(S_CYC + 20);
        chk(evt_count == n0 && !busy && !cke, "R12", "stays idle after reset",
            32'(evt_count - n0), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule